// File: doc/BRIEF.md
# Sign/Logarithm Multiply-Divide Unit

This unit does multiplicative arithmetic on numbers held in sign/logarithm form, with no multiplier array. Each operand word holds three fields: a flag marking the value as zero, a sign bit, and a two's-complement fixed-point logarithm of the magnitude. Multiplication becomes an addition of logarithms. Division becomes a subtraction. Squaring doubles the logarithm, and square root halves it. The zero flag and the sign bit are resolved separately, next to the adder.

On each cycle a caller presents two words and an operation code with a valid strobe. One clock later the unit returns the result word, a valid bit and four exception flags. A logarithm that falls outside its range saturates to the nearest end and raises overflow or underflow. Dividing by zero and taking the square root of a negative number each raise their own flag and return a fixed result word.

Top module: `lns_muldiv_unit`

## Requirements
- R1: A word is LOG_W+2 bits wide. Bit LOG_W+1 is the zero flag, bit LOG_W is the sign (1 = negative), and bits LOG_W-1:0 hold the signed logarithm with FRAC_W fraction bits. When the zero flag of an operand is set, its sign and logarithm have no effect. Every zero result is emitted as zero flag 1, sign 0, logarithm 0, with no exception flag set.
- R2: out_valid equals in_valid from the previous clock. A synchronous reset clears out_valid, out_word and all four flags.
- R3: With op_sel = 0 (multiply), the result logarithm is a+b and the sign is the XOR of the operand signs. The result is zero if either operand is zero.
- R4: With op_sel = 1 (divide) and a nonzero divisor, the result logarithm is a-b and the sign is the XOR of the operand signs. The result is zero exactly when the dividend is zero.
- R5: A divide whose divisor is zero sets div_zero. The result word then has zero flag 0, sign equal to the XOR of the operand signs, and the largest positive logarithm. This holds even when the dividend is also zero.
- R6: With op_sel = 2 (square), the result logarithm is 2a and the sign is 0. b_word is ignored, and a zero operand gives a zero result.
- R7: With op_sel = 3 (square root) and a non-negative nonzero operand, the result logarithm is a shifted arithmetically right by one, plus the bit that was shifted out, and the sign is 0. A zero operand gives a zero result even if its sign bit is set.
- R8: A square root of a nonzero negative operand sets invalid and returns the zero word.
- R9: A logarithm result above 2^(LOG_W-1)-1 saturates to that value and sets ovf.
- R10: A logarithm result below -2^(LOG_W-1) saturates to that value and sets unf.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and operation code are valid this cycle |
| op_sel | input | 2 | 0 multiply, 1 divide, 2 square, 3 square root |
| a_word | input | LOG_W+2 | First operand (dividend, or the sole operand for square and square root) |
| b_word | input | LOG_W+2 | Second operand (divisor for divide) |
| out_valid | output | 1 | Result registered from the previous cycle's strobe |
| out_word | output | LOG_W+2 | Result word |
| ovf | output | 1 | Logarithm saturated high |
| unf | output | 1 | Logarithm saturated low |
| div_zero | output | 1 | Division by a zero operand |
| invalid | output | 1 | Square root of a negative operand |

## Verification
The assertions assume that op_sel and both operand words are known values whenever in_valid is high. They also assume that any word carrying the zero flag may hold arbitrary sign and logarithm bits, which is why the zero checks look only at the result. The stimulus changes inputs only on the falling clock edge, holds them steady across the capturing edge, and drives only defined values. It deliberately places nonzero garbage in the fields of zero operands and in the unused b_word of the single-operand operations.

// File: rtl/lns_muldiv_pkg.sv
package lns_muldiv_pkg;

    // Operation codes as seen on op_sel
    typedef enum logic [1:0] {
        OP_MUL  = 2'd0,
        OP_DIV  = 2'd1,
        OP_SQR  = 2'd2,
        OP_SQRT = 2'd3
    } lns_op_e;

    // How the result word is formed
    typedef enum logic [1:0] {
        KIND_LOG     = 2'd0,  // normal: saturated logarithm
        KIND_ZERO    = 2'd1,  // canonical zero word
        KIND_DIVZERO = 2'd2,  // divisor zero: largest magnitude
        KIND_INVALID = 2'd3   // negative square root
    } res_kind_e;

    typedef struct packed {
        logic ovf;
        logic unf;
        logic div_zero;
        logic invalid;
    } exc_flags_t;

    // Sign/zero resolution, independent of the logarithm width
    typedef struct packed {
        res_kind_e kind;
        logic      sign;
    } sign_class_t;

    function automatic sign_class_t classify(input lns_op_e op,
                                             input logic za, input logic sa,
                                             input logic zb, input logic sb);
        sign_class_t r;
        r.sign = 1'b0;
        r.kind = KIND_LOG;
        unique case (op)
            OP_MUL: begin
                r.sign = sa ^ sb;
                if (za || zb) r.kind = KIND_ZERO;
            end
            OP_DIV: begin
                r.sign = sa ^ sb;
                if (zb)      r.kind = KIND_DIVZERO;
                else if (za) r.kind = KIND_ZERO;
            end
            OP_SQR: begin
                if (za) r.kind = KIND_ZERO;
            end
            OP_SQRT: begin
                if (za)      r.kind = KIND_ZERO;
                else if (sa) r.kind = KIND_INVALID;
            end
            default: r.kind = KIND_ZERO;
        endcase
        if (r.kind == KIND_ZERO || r.kind == KIND_INVALID) r.sign = 1'b0;
        return r;
    endfunction

endpackage

// File: rtl/lns_log_core.sv
module lns_log_core
    import lns_muldiv_pkg::*;
#(
    parameter int LOG_W = 8,
    localparam int EXT_W = LOG_W + 2
) (
    input  lns_op_e                  op,
    input  logic signed [LOG_W-1:0]  a_log,
    input  logic signed [LOG_W-1:0]  b_log,
    output logic signed [EXT_W-1:0]  raw_log
);
    // Two guard bits hold any sum, difference or doubling without wrap
    logic signed [EXT_W-1:0] a_ext;
    logic signed [EXT_W-1:0] b_ext;
    logic signed [EXT_W-1:0] half_a;
    logic signed [EXT_W-1:0] round_bit;

    assign a_ext     = EXT_W'(a_log);
    assign b_ext     = EXT_W'(b_log);
    assign half_a    = a_ext >>> 1;
    assign round_bit = {{(EXT_W-1){1'b0}}, a_log[0]};

    always_comb begin
        unique case (op)
            OP_MUL:  raw_log = a_ext + b_ext;
            OP_DIV:  raw_log = a_ext - b_ext;
            OP_SQR:  raw_log = a_ext + a_ext;
            OP_SQRT: raw_log = half_a + round_bit;
            default: raw_log = '0;
        endcase
    end
endmodule

// File: rtl/lns_saturate.sv
module lns_saturate #(
    parameter int LOG_W = 8,
    localparam int EXT_W = LOG_W + 2,
    localparam int HI_I  = 2 ** (LOG_W - 1) - 1,
    localparam int LO_I  = -(2 ** (LOG_W - 1))
) (
    input  logic signed [EXT_W-1:0] raw_log,
    output logic [LOG_W-1:0]        sat_log,
    output logic                    over,
    output logic                    under
);
    localparam logic signed [EXT_W-1:0] HI_X = EXT_W'(HI_I);
    localparam logic signed [EXT_W-1:0] LO_X = EXT_W'(LO_I);

    assign over  = (raw_log > HI_X);
    assign under = (raw_log < LO_X);

    always_comb begin
        if (over)       sat_log = HI_X[LOG_W-1:0];
        else if (under) sat_log = LO_X[LOG_W-1:0];
        else            sat_log = raw_log[LOG_W-1:0];
    end
endmodule

// File: rtl/lns_muldiv_unit.sv
module lns_muldiv_unit
    import lns_muldiv_pkg::*;
#(
    parameter int INT_W  = 4,
    parameter int FRAC_W = 4,
    localparam int LOG_W  = INT_W + FRAC_W,
    localparam int WORD_W = LOG_W + 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [1:0]        op_sel,
    input  logic [WORD_W-1:0] a_word,
    input  logic [WORD_W-1:0] b_word,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_word,
    output logic              ovf,
    output logic              unf,
    output logic              div_zero,
    output logic              invalid
);
    localparam int ZB = WORD_W - 1;  // zero flag position
    localparam int SB = WORD_W - 2;  // sign position
    localparam logic [LOG_W-1:0] LOG_MAX = {1'b0, {(LOG_W-1){1'b1}}};
    localparam logic [LOG_W-1:0] LOG_MIN = {1'b1, {(LOG_W-1){1'b0}}};

    lns_op_e     op;
    sign_class_t cls;
    logic signed [LOG_W+1:0] raw_log;
    logic [LOG_W-1:0] sat_log;
    logic sat_hi, sat_lo;
    logic [WORD_W-1:0] nxt_word;
    exc_flags_t        nxt_exc;

    assign op  = lns_op_e'(op_sel);
    assign cls = classify(op, a_word[ZB], a_word[SB], b_word[ZB], b_word[SB]);

    lns_log_core #(.LOG_W(LOG_W)) u_core (
        .op      (op),
        .a_log   (a_word[LOG_W-1:0]),
        .b_log   (b_word[LOG_W-1:0]),
        .raw_log (raw_log)
    );

    lns_saturate #(.LOG_W(LOG_W)) u_sat (
        .raw_log (raw_log),
        .sat_log (sat_log),
        .over    (sat_hi),
        .under   (sat_lo)
    );

    always_comb begin
        nxt_exc = '0;
        unique case (cls.kind)
            KIND_LOG: begin
                nxt_word    = {1'b0, cls.sign, sat_log};
                nxt_exc.ovf = sat_hi;
                nxt_exc.unf = sat_lo;
            end
            KIND_DIVZERO: begin
                nxt_word         = {1'b0, cls.sign, LOG_MAX};
                nxt_exc.div_zero = 1'b1;
            end
            KIND_INVALID: begin
                nxt_word        = {1'b1, 1'b0, {LOG_W{1'b0}}};
                nxt_exc.invalid = 1'b1;
            end
            default: nxt_word = {1'b1, 1'b0, {LOG_W{1'b0}}};
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_word  <= '0;
            ovf       <= 1'b0;
            unf       <= 1'b0;
            div_zero  <= 1'b0;
            invalid   <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_word <= nxt_word;
                ovf      <= nxt_exc.ovf;
                unf      <= nxt_exc.unf;
                div_zero <= nxt_exc.div_zero;
                invalid  <= nxt_exc.invalid;
            end
        end
    end

    // R2: one-cycle latency of the strobe
    a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    a_r2_idle_follows: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    // R1: a zero result is canonical and carries no exception
    a_r1_zero_canonical: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_word[ZB] && !invalid) |->
            (out_word[SB] == 1'b0 && out_word[LOG_W-1:0] == '0 && !ovf && !unf && !div_zero));

    // R9 / R10: saturation flags match the end value and exclude each other
    a_r9_no_overflow_and_underflow: assert property (@(posedge clk) disable iff (rst)
        !(ovf && unf));
    a_r9_ovf_at_max: assert property (@(posedge clk) disable iff (rst)
        ovf |-> (out_word[LOG_W-1:0] == LOG_MAX && !out_word[ZB]));
    a_r10_unf_at_min: assert property (@(posedge clk) disable iff (rst)
        unf |-> (out_word[LOG_W-1:0] == LOG_MIN && !out_word[ZB]));

    // R5: divide-by-zero only from a divide with a zero divisor
    a_r5_div_zero_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(div_zero) |-> ($past(in_valid) && $past(op_sel) == 2'd1 && $past(b_word[ZB])));

    // R7: square root can never leave the logarithm range
    a_r7_sqrt_in_range: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_sel == 2'd3) |=> (!ovf && !unf));

    // R8: invalid comes with the zero word
    a_r8_invalid_zero: assert property (@(posedge clk) disable iff (rst)
        invalid |-> (out_word[ZB] && !div_zero));
endmodule

// File: tb/lns_muldiv_unit_bench.sv
module lns_muldiv_unit_bench;
    localparam int LOG_W  = 8;
    localparam int WORD_W = LOG_W + 2;
    localparam int NV     = 20;

    logic clk = 1'b0;
    logic rst;
    logic in_valid;
    logic [1:0] op_sel;
    logic [WORD_W-1:0] a_word, b_word;
    logic out_valid;
    logic [WORD_W-1:0] out_word;
    logic ovf, unf, div_zero, invalid;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;  // 50 MHz

    lns_muldiv_unit u_lns_muldiv_unit (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op_sel(op_sel),
        .a_word(a_word), .b_word(b_word), .out_valid(out_valid),
        .out_word(out_word), .ovf(ovf), .unf(unf),
        .div_zero(div_zero), .invalid(invalid)
    );

    // {op, a{z,s,log}, b{z,s,log}, expected{z,s,log}, flags{ovf,unf,divz,inv}}
    localparam logic [35:0] VEC [NV] = '{
        {2'd0, 1'b0,1'b0,8'd16,      1'b0,1'b1,8'd32,      1'b0,1'b1,8'd48,     4'b0000}, // R3
        {2'd0, 1'b0,1'b1,-8'sd20,    1'b0,1'b1,8'd5,       1'b0,1'b0,-8'sd15,   4'b0000}, // R3
        {2'd0, 1'b1,1'b1,8'd77,      1'b0,1'b1,8'd3,       1'b1,1'b0,8'd0,      4'b0000}, // R1
        {2'd0, 1'b0,1'b0,8'd127,     1'b1,1'b1,8'd127,     1'b1,1'b0,8'd0,      4'b0000}, // R1
        {2'd0, 1'b0,1'b0,8'd100,     1'b0,1'b0,8'd50,      1'b0,1'b0,8'd127,    4'b1000}, // R9
        {2'd0, 1'b0,1'b0,-8'sd100,   1'b0,1'b1,-8'sd60,    1'b0,1'b1,-8'sd128,  4'b0100}, // R10
        {2'd0, 1'b0,1'b0,8'd127,     1'b0,1'b0,-8'sd128,   1'b0,1'b0,-8'sd1,    4'b0000}, // R3
        {2'd1, 1'b0,1'b1,8'd40,      1'b0,1'b0,8'd15,      1'b0,1'b1,8'd25,     4'b0000}, // R4
        {2'd1, 1'b1,1'b0,8'd9,       1'b0,1'b1,8'd3,       1'b1,1'b0,8'd0,      4'b0000}, // R4
        {2'd1, 1'b0,1'b0,8'd100,     1'b0,1'b0,-8'sd50,    1'b0,1'b0,8'd127,    4'b1000}, // R9
        {2'd1, 1'b0,1'b0,-8'sd100,   1'b0,1'b1,8'd90,      1'b0,1'b1,-8'sd128,  4'b0100}, // R10
        {2'd1, 1'b0,1'b1,8'd5,       1'b1,1'b0,8'd0,       1'b0,1'b1,8'd127,    4'b0010}, // R5
        {2'd1, 1'b1,1'b0,8'd0,       1'b1,1'b0,8'd0,       1'b0,1'b0,8'd127,    4'b0010}, // R5
        {2'd2, 1'b0,1'b1,-8'sd30,    1'b0,1'b1,8'd99,      1'b0,1'b0,-8'sd60,   4'b0000}, // R6
        {2'd2, 1'b0,1'b0,8'd70,      1'b1,1'b1,8'd1,       1'b0,1'b0,8'd127,    4'b1000}, // R9
        {2'd2, 1'b0,1'b0,-8'sd70,    1'b0,1'b0,8'd0,       1'b0,1'b0,-8'sd128,  4'b0100}, // R10
        {2'd3, 1'b0,1'b0,8'd33,      1'b0,1'b1,8'd44,      1'b0,1'b0,8'd17,     4'b0000}, // R7
        {2'd3, 1'b0,1'b0,-8'sd33,    1'b1,1'b0,8'd0,       1'b0,1'b0,-8'sd16,   4'b0000}, // R7
        {2'd3, 1'b0,1'b1,8'd32,      1'b0,1'b0,8'd2,       1'b1,1'b0,8'd0,      4'b0001}, // R8
        {2'd3, 1'b1,1'b1,8'd5,       1'b0,1'b0,8'd2,       1'b1,1'b0,8'd0,      4'b0000}  // R7
    };

    localparam string TAG [NV] = '{"R3","R3","R1","R1","R9","R10","R3","R4","R4","R9",
                                   "R10","R5","R5","R6","R9","R10","R7","R7","R8","R7"};

    task automatic check(input string req, input logic [14:0] act, input logic [14:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got valid/word/flags %h, expected %h", req, act, exp);
        end
    endtask

    function automatic logic [14:0] observed();
        return {out_valid, out_word, ovf, unf, div_zero, invalid};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        rst = 1'b1; in_valid = 1'b0; op_sel = '0;
        a_word = 10'h155; b_word = 10'h2AA;
        repeat (3) @(negedge clk);
        check("R2 reset", observed(), 15'h0);
        rst = 1'b0;

        // vector table walk
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            op_sel = VEC[i][35:34]; a_word = VEC[i][33:24]; b_word = VEC[i][23:14];
            in_valid = 1'b1;
            @(negedge clk);
            check(TAG[i], observed(), {1'b1, VEC[i][13:0]});
        end

        // R2: no strobe -> out_valid low, word held
        in_valid = 1'b0;
        @(negedge clk);
        check("R2 idle", observed(), {1'b0, 1'b1,1'b0,8'd0, 4'b0000});

        // R2: back-to-back strobes, each result one cycle later
        op_sel = 2'd0; a_word = {2'b00, 8'd3}; b_word = {2'b00, 8'd4}; in_valid = 1'b1;
        @(negedge clk);
        check("R3 b2b first", observed(), {1'b1, 2'b00, 8'd7, 4'b0000});
        op_sel = 2'd3; a_word = {2'b00, 8'd7}; b_word = '0;
        @(negedge clk);
        check("R7 b2b second", observed(), {1'b1, 2'b00, 8'd4, 4'b0000});

        // R2: reset mid-stream clears outputs
        op_sel = 2'd1; a_word = {2'b00, 8'd1}; b_word = {2'b10, 8'd0};
        rst = 1'b1;
        @(negedge clk);
        check("R2 reset mid", observed(), 15'h0);
        rst = 1'b0; in_valid = 1'b0;
        @(negedge clk);
        check("R2 after reset", observed(), 15'h0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule